// File: doc/BRIEF.md
# Agent-Filtered Event Counter

This block is a performance monitor that sits next to one system device, such as a cache, an I/O bridge or a memory controller. It holds four 32-bit event counters. Each counter is given an event code. The code picks one of three sources: every clock, one pulse every 64 clocks, or one of the device's external event strobes. An external strobe carries the ID of the agent whose request caused it. It is counted only when that agent's bit is set in a 64-bit agent mask.

Software uses a single-cycle 32-bit register port to program and read the counters, event codes, masks and enables. When a counter wraps past its top value, it sets a sticky overflow bit. A level interrupt is raised while any overflow bit is set whose interrupt enable is also on. A revision parameter chooses how software clears the overflow bits, and whether one counter or four are present.

Top module: `agent_event_counter`

## Requirements
- R1: Counter n (n = 0..3) reads and writes at byte offset 0x000 + 4n. It is 32 bits wide and wraps modulo 2^32. A register write to a counter loads the written value in that cycle, and the write wins over any increment in the same cycle.
- R2: The event code register of counter n is at 0x400 + 4n (8 bits). Code 0 counts every clock. Code 1 counts once every 64 clocks, driven by a free-running prescaler. Code c from 2 to EXT_EVENTS+1 counts strobe evt_strobe[c-2]. Any higher code never counts.
- R3: Agents 0..31 are masked at 0xA00, where bit k is agent k. Agents 32..63 are masked at 0xA04, where bit k is agent 32+k. A strobe counts only if the mask bit of its agent ID is 1. Codes 0 and 1 are not filtered by agent.
- R4: Counter enables are set by writing 1s at 0xC00 and cleared by writing 1s at 0xC20. Bit n belongs to counter n. A read of either address returns the enable vector.
- R5: The control register is at 0xE04. Bit 0 is the global enable and reads back as written. While it is 0, no counter advances.
- R6: Writing 1 to control bit 1 zeroes all counters at that clock edge, taking priority over increments. Bit 1 always reads 0.
- R7: Overflow status is at 0xC80. Bit n becomes 1 when counter n increments from 0xFFFFFFFF to 0. The bit stays set until software clears it.
- R8: With REVISION=2, writing 1s to 0xC80 clears the matching status bits, and writing 0s has no effect. An overflow in the same cycle as its clear leaves the bit set.
- R9: With REVISION=1, only counter 0 exists: counters 1..3 and their enable bits read 0. A write of value 0 to 0xC80 clears all status bits, and a nonzero write has no effect.
- R10: Interrupt enables are set by writing 1s at 0xC40 and cleared by writing 1s at 0xC60. irq is high whenever some status bit and its interrupt enable are both 1. It falls on the cycle after the clearing write.
- R11: After reset, the counters, event codes, enables, status, global enable and irq are all 0, and both agent masks are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_strobe | input | EXT_EVENTS | External event strobes; bit k is event code k+2 |
| evt_agent | input | EXT_EVENTS*AGENT_W | Agent ID for each strobe; field k is bits [k*AGENT_W +: AGENT_W] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address; only word-aligned addresses are decoded |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 1 | Level overflow interrupt |

## Verification
The agent filter is swept over all 64 agent IDs, one strobe per ID. An irregular mask pattern is used in both mask words, so a wrong bit index or a swapped mask word gives a different running total. The cycle event is timed over a 100-clock window and the divide-by-64 event over a 640-clock window; 640 holds exactly ten prescaler pulses whatever the phase. Overflow is driven from preloaded values near the top of the range to separate four cases: a plain wrap, a wrap together with a clear, clearing by ones versus clearing by zero, and interrupt masking. A second instance at the older revision receives the same writes, so the two clear rules and the single-counter limit are compared side by side.

// File: rtl/agent_event_counter.sv
module agent_event_counter #(
  parameter int REVISION   = 2,
  parameter int EXT_EVENTS = 30,
  parameter int AGENT_W    = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [EXT_EVENTS-1:0]         evt_strobe,
  input  logic [EXT_EVENTS*AGENT_W-1:0] evt_agent,
  input  logic                          reg_we,
  input  logic [11:0]                   reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  output logic                          irq
);
  localparam int NCNT = 4;
  localparam int PRE_W = 6;
  localparam int CODES = 256;
  localparam logic [NCNT-1:0] IMPL = (REVISION == 1) ? 4'b0001 : 4'b1111;

  localparam logic [9:0] W_MASK0 = 10'h280;
  localparam logic [9:0] W_MASK1 = 10'h281;
  localparam logic [9:0] W_ENSET = 10'h300;
  localparam logic [9:0] W_ENCLR = 10'h308;
  localparam logic [9:0] W_IESET = 10'h310;
  localparam logic [9:0] W_IECLR = 10'h318;
  localparam logic [9:0] W_OVF   = 10'h320;
  localparam logic [9:0] W_CTRL  = 10'h381;

  logic [31:0]      cnt_q [NCNT];
  logic [7:0]       code_q [NCNT];
  logic [63:0]      amask_q;
  logic [NCNT-1:0]  cnten_q, inten_q, ovf_q;
  logic             gen_en;
  logic [PRE_W-1:0] presc_q;

  wire [9:0] word    = reg_addr[11:2];
  wire       wsel    = reg_we && (reg_addr[1:0] == 2'b00);
  wire       clr_all = wsel && (word == W_CTRL) && reg_wdata[1];
  wire       tick    = &presc_q;

  logic [EXT_EVENTS-1:0] ext_ok;
  logic [CODES-1:0]      ev_all;
  logic [NCNT-1:0]       cnt_wr, code_wr, inc, wrap, ovf_clr;

  always_comb begin
    for (int k = 0; k < EXT_EVENTS; k++)
      ext_ok[k] = evt_strobe[k] && amask_q[6'(evt_agent[k*AGENT_W +: AGENT_W])];
    ev_all = {{(CODES-EXT_EVENTS-2){1'b0}}, ext_ok, tick, 1'b1};
    for (int n = 0; n < NCNT; n++) begin
      cnt_wr[n]  = wsel && (word == 10'(n)) && IMPL[n];
      code_wr[n] = wsel && (word == 10'(n + 'h100)) && IMPL[n];
      inc[n]     = IMPL[n] && gen_en && cnten_q[n] && ev_all[code_q[n]];
      wrap[n]    = inc[n] && !cnt_wr[n] && !clr_all && (&cnt_q[n]);
    end
    if (REVISION == 1)
      ovf_clr = (wsel && word == W_OVF && reg_wdata == 32'd0) ? '1 : '0;
    else
      ovf_clr = (wsel && word == W_OVF) ? reg_wdata[NCNT-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NCNT; n++) begin
        cnt_q[n]  <= '0;
        code_q[n] <= '0;
      end
    end else begin
      for (int n = 0; n < NCNT; n++) begin
        if (clr_all)        cnt_q[n] <= '0;
        else if (cnt_wr[n]) cnt_q[n] <= reg_wdata;
        else if (inc[n])    cnt_q[n] <= cnt_q[n] + 32'd1;
        if (code_wr[n])     code_q[n] <= reg_wdata[7:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amask_q <= '1;
      cnten_q <= '0;
      inten_q <= '0;
      ovf_q   <= '0;
      gen_en  <= 1'b0;
      presc_q <= '0;
    end else begin
      presc_q <= presc_q + 1'b1;
      if (wsel && word == W_MASK0) amask_q[31:0]  <= reg_wdata;
      if (wsel && word == W_MASK1) amask_q[63:32] <= reg_wdata;
      if (wsel && word == W_ENSET) cnten_q <= cnten_q | (reg_wdata[NCNT-1:0] & IMPL);
      if (wsel && word == W_ENCLR) cnten_q <= cnten_q & ~reg_wdata[NCNT-1:0];
      if (wsel && word == W_IESET) inten_q <= inten_q | (reg_wdata[NCNT-1:0] & IMPL);
      if (wsel && word == W_IECLR) inten_q <= inten_q & ~reg_wdata[NCNT-1:0];
      if (wsel && word == W_CTRL)  gen_en  <= reg_wdata[0];
      ovf_q <= (ovf_q & ~ovf_clr) | wrap;
    end
  end

  assign irq = |(ovf_q & inten_q);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[1:0] == 2'b00) begin
      if (word[9:2] == 8'h00)      reg_rdata = cnt_q[word[1:0]];
      else if (word[9:2] == 8'h40) reg_rdata = {24'd0, code_q[word[1:0]]};
      else begin
        case (word)
          W_MASK0:          reg_rdata = amask_q[31:0];
          W_MASK1:          reg_rdata = amask_q[63:32];
          W_ENSET, W_ENCLR: reg_rdata = {28'd0, cnten_q};
          W_IESET, W_IECLR: reg_rdata = {28'd0, inten_q};
          W_OVF:            reg_rdata = {28'd0, ovf_q};
          W_CTRL:           reg_rdata = {31'd0, gen_en};
          default:          reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/agent_event_counter_chk.sv
module agent_event_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic        irq,
  input logic        gen,
  input logic        ovf0,
  input logic [31:0] cnt0,
  input logic [31:0] cnt1
);
  a_r1_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 12'h000) |=> (cnt0 == $past(reg_wdata)));

  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen && !reg_we) |=> $stable(cnt0));

  a_r6_zero_all: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 12'hE04 && reg_wdata[1]) |=> (cnt0 == 32'd0 && cnt1 == 32'd0));

  a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf0 && !(reg_we && reg_addr == 12'hC80)) |=> ovf0);

  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_we && (reg_addr == 12'hC80 || reg_addr == 12'hC60))) |=> irq);
endmodule

bind agent_event_counter agent_event_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .gen(gen_en), .ovf0(ovf_q[0]),
  .cnt0(cnt_q[0]), .cnt1(cnt_q[1])
);

// File: tb/agent_event_counter_bench.sv
module agent_event_counter_bench;
  localparam int EXT = 30;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [EXT-1:0] evt_strobe = '0;
  logic [EXT*AW-1:0] evt_agent = '0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata, rdata_r1;
  logic irq, irq_r1;
  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  agent_event_counter #(.REVISION(2), .EXT_EVENTS(EXT), .AGENT_W(AW)) u_agent_event_counter (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .evt_agent(evt_agent),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata), .irq(irq));

  agent_event_counter #(.REVISION(1), .EXT_EVENTS(EXT), .AGENT_W(AW)) u_agent_event_counter_r1 (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .evt_agent(evt_agent),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_r1), .irq(irq_r1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic [31:0] d1);
    reg_addr = a;
    #1;
    d = rdata;
    d1 = rdata_r1;
  endtask

  task automatic pulse(input int idx, input logic [AW-1:0] ag);
    evt_strobe[idx] = 1'b1;
    evt_agent[idx*AW +: AW] = ag;
    @(negedge clk);
    evt_strobe[idx] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v, v1;
    logic [63:0] m;
    int exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    for (int n = 0; n < 4; n++) begin
      rd(12'(4*n), v, v1); chk("R11 counter", v, 0);
      rd(12'(12'h400 + 4*n), v, v1); chk("R11 code", v, 0);
    end
    rd(12'hC00, v, v1); chk("R11 enables", v, 0);
    rd(12'hC80, v, v1); chk("R11 status", v, 0);
    rd(12'hE04, v, v1); chk("R11 control", v, 0);
    rd(12'hA00, v, v1); chk("R11 mask0", v, 32'hFFFF_FFFF);
    rd(12'hA04, v, v1); chk("R11 mask1", v, 32'hFFFF_FFFF);
    chk("R11 irq", {31'd0, irq}, 0);

    // R2 cycle event over 100 enabled edges
    wr(12'h400, 0); wr(12'hC00, 1); wr(12'hE04, 1);
    repeat (99) @(negedge clk);
    wr(12'hE04, 0);
    rd(12'h000, v, v1); chk("R2 cycle count", v, 100);
    // R5 global enable off
    repeat (20) @(negedge clk);
    rd(12'h000, v, v1); chk("R5 frozen when off", v, 100);
    rd(12'hE04, v, v1); chk("R5 control readback", v, 0);

    // R1 preload and write priority
    wr(12'h000, 32'h1234_5678);
    rd(12'h000, v, v1); chk("R1 preload", v, 32'h1234_5678);
    wr(12'hE04, 1);
    wr(12'h000, 32'hABCD_0000);
    rd(12'h000, v, v1); chk("R1 write beats increment", v, 32'hABCD_0000);
    wr(12'hE04, 0);
    rd(12'h000, v, v1); chk("R1 increment after write", v, 32'hABCD_0001);

    // R2 divide-by-64 over 640 edges
    wr(12'h404, 1); wr(12'hC00, 2);
    wr(12'hE04, 1);
    repeat (639) @(negedge clk);
    wr(12'hE04, 0);
    rd(12'h004, v, v1); chk("R2 div64 count", v, 10);

    // R4 enable set/clear
    rd(12'hC00, v, v1); chk("R4 set view", v, 3);
    rd(12'hC20, v, v1); chk("R4 clear view", v, 3);
    wr(12'hC20, 1);
    rd(12'hC00, v, v1); chk("R4 after clear", v, 2);

    // R3 agent sweep on counter 2, code 7 = strobe 5
    m = 64'h8000_7E11_A5C3_0F01;
    wr(12'hC20, 32'hF);
    wr(12'h408, 7); wr(12'h40C, 8);
    wr(12'hA00, m[31:0]); wr(12'hA04, m[63:32]);
    wr(12'h008, 0); wr(12'h00C, 0);
    wr(12'hC00, 32'hC); wr(12'hE04, 1);
    exp = 0;
    for (int a = 0; a < 64; a++) begin
      pulse(5, AW'(a));
      if (m[a]) exp++;
      rd(12'h008, v, v1); chk("R3 agent filter", v, 32'(exp));
    end
    rd(12'h00C, v, v1); chk("R2 unselected strobe", v, 0);
    wr(12'hE04, 0);
    pulse(5, 6'd0);
    rd(12'h008, v, v1); chk("R5 strobe ignored when off", v, 32'(exp));

    // R7 / R10 overflow on counter 3
    wr(12'hC20, 4); wr(12'h40C, 0);
    wr(12'h00C, 32'hFFFF_FFFE); wr(12'hC40, 8);
    wr(12'hE04, 1); wr(12'hE04, 0);
    rd(12'h00C, v, v1); chk("R7 at top", v, 32'hFFFF_FFFF);
    rd(12'hC80, v, v1); chk("R7 no status yet", v, 0);
    wr(12'hE04, 1); wr(12'hE04, 0);
    rd(12'h00C, v, v1); chk("R1 wrap to zero", v, 0);
    rd(12'hC80, v, v1); chk("R7 status set", v, 8);
    chk("R10 irq raised", {31'd0, irq}, 1);
    wr(12'hC80, 0);
    rd(12'hC80, v, v1); chk("R8 zero write ignored", v, 8);
    wr(12'hC80, 1);
    rd(12'hC80, v, v1); chk("R8 other bit clear", v, 8);
    wr(12'hC60, 8);
    chk("R10 irq masked", {31'd0, irq}, 0);
    wr(12'hC40, 8);
    chk("R10 irq unmasked", {31'd0, irq}, 1);
    wr(12'hC80, 8);
    rd(12'hC80, v, v1); chk("R8 clear by one", v, 0);
    chk("R10 irq after clear", {31'd0, irq}, 0);

    // R8 overflow coinciding with clear
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'hE04, 1); wr(12'hE04, 0);
    rd(12'hC80, v, v1); chk("R7 status again", v, 8);
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'hE04, 1);
    wr(12'hC80, 8);
    wr(12'hE04, 0);
    rd(12'hC80, v, v1); chk("R8 new overflow kept", v, 8);
    rd(12'h00C, v, v1); chk("R1 count after wrap", v, 1);

    // R6 zero-all control bit
    wr(12'hC00, 32'hF);
    wr(12'hE04, 3);
    for (int n = 0; n < 4; n++) begin
      rd(12'(4*n), v, v1); chk("R6 counters zeroed", v, 0);
    end
    rd(12'hE04, v, v1); chk("R6 bit reads zero", v, 1);
    wr(12'hE04, 0);

    // R9 revision 1 behaviour
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    wr(12'hC00, 32'hF);
    rd(12'hC00, v, v1); chk("R9 single enable bit", v1, 1);
    chk("R4 four enable bits", v, 32'hF);
    wr(12'h004, 5);
    rd(12'h004, v, v1); chk("R9 counter1 absent", v1, 0);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'hE04, 1); wr(12'hE04, 0);
    rd(12'hC80, v, v1); chk("R9 status set", v1, 1);
    wr(12'hC80, 1);
    rd(12'hC80, v, v1);
    chk("R9 nonzero write ignored", v1, 1);
    chk("R8 one clears", v, 0);
    wr(12'hC80, 0);
    rd(12'hC80, v, v1); chk("R9 zero write clears", v1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule